// File: doc/BRIEF.md
# Memory Board Data Path Registers

This block is the word-wide register path of a memory board. Every word read from storage is caught in a staging register and then delayed through a three-word buffer. The buffer output is turned into corrected data by XOR with a flip mask, which arrives as a plain input vector. When the active-low correction strobe is high, the mask is forced to zero and the buffer word passes through unchanged.

Three holding registers capture the input word, the corrected word and the raw staged word. Any one of them can be placed on a shared result bus through its own active-low enable. When none is enabled, the result bus carries whatever an outside source drives on it. An output register and a storage-write register each choose their source with select lines. The write register drives storage in inverted form.

The block has no state machine. All of its registers load on every clock, gated only by their selects and by the input-holding load enable.

Top module: `mem_datapath`

## Requirements
- R1: A synchronous reset (`rst` high) clears every register and the buffer to zero, so after reset `out_data` reads 0, `stor_out_n` reads all ones, and each holding register reads 0 on the result bus.
- R2: A word sampled on `stor_din` at clock edge k reaches the raw holding register at edge k+1 and the corrected holding register at edge k+4, because the staging register feeds a three-word buffer.
- R3: Corrected data equals the buffer output XOR `flip_mask` when `fix_n` is 0; when `fix_n` is 1, the mask has no effect and corrected data equals the buffer output.
- R4: The input holding register loads `in_data` on an edge only when `hold_in_en` is 1, and keeps its value when `hold_in_en` is 0.
- R5: Driving `rd_in_n`, `rd_cor_n` or `rd_raw_n` low places the input, corrected or raw holding register, respectively, on `rbus`, and sets `rbus_driven` to 1.
- R6: When all three enables are high, `rbus` equals `bus_ext` and `rbus_driven` is 0.
- R7: On each edge, the output register loads corrected data when `out_sel_n` is 0 and loads `rbus` when `out_sel_n` is 1.
- R8: On each edge, the write register loads `rbus` when `wr_sel` is 0. When `wr_sel` is 1, it loads the source chosen by `mux_sel`: corrected data when `mux_sel` is 1, and `in_data` when `mux_sel` is 0.
- R9: `stor_out_n` is always the bitwise inverse of the write register.
- R10: At most one of the three bus enables may be low in any cycle; two or more low at once is a usage error that the checker flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stor_din | input | W | Data read from storage |
| in_data | input | W | Input data word |
| flip_mask | input | W | Correction flip mask |
| fix_n | input | 1 | Correction strobe, active low; when high the mask is zeroed |
| hold_in_en | input | 1 | Load enable of the input holding register |
| rd_in_n | input | 1 | Places the input holding register on the result bus, active low |
| rd_cor_n | input | 1 | Places the corrected holding register on the result bus, active low |
| rd_raw_n | input | 1 | Places the raw holding register on the result bus, active low |
| bus_ext | input | W | External value of the result bus when no enable is low |
| out_sel_n | input | 1 | Output register source: 0 corrected data, 1 result bus |
| wr_sel | input | 1 | Write register source: 1 input mux, 0 result bus |
| mux_sel | input | 1 | Input mux: 1 corrected data, 0 input data |
| rbus | output | W | Resolved result bus |
| rbus_driven | output | 1 | High when a holding register drives the result bus |
| out_data | output | W | Output data register |
| stor_out_n | output | W | Inverted write register, sent to storage |

## Verification
The bench walks a single one and a single zero through all sixteen bit positions. Each word travels through staging, the buffer, both holding registers, the output register and the write register. A swapped select, a missing inversion or a stuck bit shows up as a wrong value at one exact position. A numbered word sequence checks that the raw holding register is one edge behind the input and the corrected one is four edges behind. A buffer one stage too short or too long would return the neighbouring word. Further checks apply a mask with `fix_n` both low and high, hold a value with the load enable off, and let an external value through an undriven bus. An inverted strobe, an input register that loads regardless of its enable, or a bus that fails to release would each change an output seen at the ports.

// File: rtl/mdp_pkg.sv
package mdp_pkg;
    localparam int unsigned DEF_W     = 16;
    localparam int unsigned DEF_DEPTH = 3;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_IN   = 2'd1,
        SRC_COR  = 2'd2,
        SRC_RAW  = 2'd3
    } bus_src_e;

    function automatic bus_src_e pick_src(input logic in_n, input logic cor_n, input logic raw_n);
        if (!in_n)       return SRC_IN;
        else if (!cor_n) return SRC_COR;
        else if (!raw_n) return SRC_RAW;
        else             return SRC_NONE;
    endfunction
endpackage

// File: rtl/mdp_stage_buf.sv
module mdp_stage_buf #(
    parameter int unsigned W     = mdp_pkg::DEF_W,
    parameter int unsigned DEPTH = mdp_pkg::DEF_DEPTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] stage_q,
    output logic [W-1:0] buf_q
);
    localparam int unsigned LAST = DEPTH - 1;

    logic [W-1:0] word_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= din;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) word_q[g] <= '0;
                else     word_q[g] <= stage_q;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst) word_q[g] <= '0;
                else     word_q[g] <= word_q[g-1];
            end
        end
    end

    assign buf_q = word_q[LAST];
endmodule

// File: rtl/mdp_hold_bank.sv
module mdp_hold_bank #(
    parameter int unsigned W = mdp_pkg::DEF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] in_data,
    input  logic         hold_in_en,
    input  logic [W-1:0] cor_data,
    input  logic [W-1:0] raw_data,
    input  logic         en_in_n,
    input  logic         en_cor_n,
    input  logic         en_raw_n,
    input  logic [W-1:0] bus_ext,
    output logic [W-1:0] hold_in_q,
    output logic [W-1:0] hold_cor_q,
    output logic [W-1:0] hold_raw_q,
    output logic [W-1:0] rbus,
    output logic         rbus_driven
);
    import mdp_pkg::*;

    bus_src_e src;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_in_q  <= '0;
            hold_cor_q <= '0;
            hold_raw_q <= '0;
        end else begin
            if (hold_in_en) hold_in_q <= in_data;
            hold_cor_q <= cor_data;
            hold_raw_q <= raw_data;
        end
    end

    always_comb begin
        src = pick_src(en_in_n, en_cor_n, en_raw_n);
        unique case (src)
            SRC_IN:   rbus = hold_in_q;
            SRC_COR:  rbus = hold_cor_q;
            SRC_RAW:  rbus = hold_raw_q;
            SRC_NONE: rbus = bus_ext;
            default:  rbus = bus_ext;
        endcase
        rbus_driven = (src != SRC_NONE);
    end
endmodule

// File: rtl/mdp_out_regs.sv
module mdp_out_regs #(
    parameter int unsigned W = mdp_pkg::DEF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cor_data,
    input  logic [W-1:0] in_data,
    input  logic [W-1:0] rbus,
    input  logic         out_sel_n,
    input  logic         wr_sel,
    input  logic         mux_sel,
    output logic [W-1:0] out_data,
    output logic [W-1:0] stor_out_n
);
    logic [W-1:0] wr_q;
    logic [W-1:0] imux;

    always_comb begin
        imux = mux_sel ? cor_data : in_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_data <= '0;
            wr_q     <= '0;
        end else begin
            out_data <= out_sel_n ? rbus : cor_data;
            wr_q     <= wr_sel ? imux : rbus;
        end
    end

    assign stor_out_n = ~wr_q;
endmodule

// File: rtl/mem_datapath.sv
module mem_datapath #(
    parameter int unsigned W     = mdp_pkg::DEF_W,
    parameter int unsigned DEPTH = mdp_pkg::DEF_DEPTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] stor_din,
    input  logic [W-1:0] in_data,
    input  logic [W-1:0] flip_mask,
    input  logic         fix_n,
    input  logic         hold_in_en,
    input  logic         rd_in_n,
    input  logic         rd_cor_n,
    input  logic         rd_raw_n,
    input  logic [W-1:0] bus_ext,
    input  logic         out_sel_n,
    input  logic         wr_sel,
    input  logic         mux_sel,
    output logic [W-1:0] rbus,
    output logic         rbus_driven,
    output logic [W-1:0] out_data,
    output logic [W-1:0] stor_out_n
);
    logic [W-1:0] stage_q;
    logic [W-1:0] buf_q;
    logic [W-1:0] mask_eff;
    logic [W-1:0] cor_data;
    logic [W-1:0] hold_in_q;
    logic [W-1:0] hold_cor_q;
    logic [W-1:0] hold_raw_q;

    mdp_stage_buf #(.W(W), .DEPTH(DEPTH)) u_stage (
        .clk     (clk),
        .rst     (rst),
        .din     (stor_din),
        .stage_q (stage_q),
        .buf_q   (buf_q)
    );

    always_comb begin
        mask_eff = fix_n ? '0 : flip_mask;
        cor_data = buf_q ^ mask_eff;
    end

    mdp_hold_bank #(.W(W)) u_hold (
        .clk         (clk),
        .rst         (rst),
        .in_data     (in_data),
        .hold_in_en  (hold_in_en),
        .cor_data    (cor_data),
        .raw_data    (stage_q),
        .en_in_n     (rd_in_n),
        .en_cor_n    (rd_cor_n),
        .en_raw_n    (rd_raw_n),
        .bus_ext     (bus_ext),
        .hold_in_q   (hold_in_q),
        .hold_cor_q  (hold_cor_q),
        .hold_raw_q  (hold_raw_q),
        .rbus        (rbus),
        .rbus_driven (rbus_driven)
    );

    mdp_out_regs #(.W(W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .cor_data   (cor_data),
        .in_data    (in_data),
        .rbus       (rbus),
        .out_sel_n  (out_sel_n),
        .wr_sel     (wr_sel),
        .mux_sel    (mux_sel),
        .out_data   (out_data),
        .stor_out_n (stor_out_n)
    );
endmodule

// File: rtl/mdp_checker.sv
module mdp_checker #(
    parameter int unsigned W = mdp_pkg::DEF_W
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] stor_din,
    input logic         hold_in_en,
    input logic         rd_in_n,
    input logic         rd_cor_n,
    input logic         rd_raw_n,
    input logic [W-1:0] bus_ext,
    input logic         out_sel_n,
    input logic         wr_sel,
    input logic [W-1:0] rbus,
    input logic         rbus_driven,
    input logic [W-1:0] out_data,
    input logic [W-1:0] stor_out_n,
    input logic [W-1:0] hold_in_q,
    input logic [W-1:0] hold_raw_q
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (out_data == '0 && stor_out_n == '1 && hold_in_q == '0 && hold_raw_q == '0));

    a_r2_raw_latency: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (hold_raw_q == $past(stor_din, 2)));

    a_r4_hold_keeps: assert property (@(posedge clk) disable iff (rst)
        !hold_in_en |=> (hold_in_q == $past(hold_in_q)));

    a_r6_bus_released: assert property (@(posedge clk) disable iff (rst)
        (rd_in_n && rd_cor_n && rd_raw_n) |-> (rbus == bus_ext && !rbus_driven));

    a_r7_out_from_bus: assert property (@(posedge clk) disable iff (rst)
        out_sel_n |=> (out_data == $past(rbus)));

    a_r9_write_inverted: assert property (@(posedge clk) disable iff (rst)
        !wr_sel |=> (stor_out_n == ~$past(rbus)));

    a_r10_single_driver: assert property (@(posedge clk) disable iff (rst)
        $countones(~{rd_in_n, rd_cor_n, rd_raw_n}) <= 1);
endmodule

bind mem_datapath mdp_checker #(.W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .stor_din    (stor_din),
    .hold_in_en  (hold_in_en),
    .rd_in_n     (rd_in_n),
    .rd_cor_n    (rd_cor_n),
    .rd_raw_n    (rd_raw_n),
    .bus_ext     (bus_ext),
    .out_sel_n   (out_sel_n),
    .wr_sel      (wr_sel),
    .rbus        (rbus),
    .rbus_driven (rbus_driven),
    .out_data    (out_data),
    .stor_out_n  (stor_out_n),
    .hold_in_q   (hold_in_q),
    .hold_raw_q  (hold_raw_q)
);

// File: tb/tb_mem_datapath.sv
module tb_mem_datapath;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] stor_din = '0, in_data = '0, flip_mask = '0, bus_ext = '0;
    logic         fix_n = 1'b1, hold_in_en = 1'b1;
    logic         rd_in_n = 1'b1, rd_cor_n = 1'b1, rd_raw_n = 1'b1;
    logic         out_sel_n = 1'b1, wr_sel = 1'b0, mux_sel = 1'b0;
    logic [W-1:0] rbus, out_data, stor_out_n;
    logic         rbus_driven;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    mem_datapath #(.W(W), .DEPTH(3)) dut (
        .clk(clk), .rst(rst), .stor_din(stor_din), .in_data(in_data),
        .flip_mask(flip_mask), .fix_n(fix_n), .hold_in_en(hold_in_en),
        .rd_in_n(rd_in_n), .rd_cor_n(rd_cor_n), .rd_raw_n(rd_raw_n),
        .bus_ext(bus_ext), .out_sel_n(out_sel_n), .wr_sel(wr_sel),
        .mux_sel(mux_sel), .rbus(rbus), .rbus_driven(rbus_driven),
        .out_data(out_data), .stor_out_n(stor_out_n)
    );

    always #10 clk = ~clk;

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_read(input int which, output logic [W-1:0] v);
        rd_in_n = (which != 0); rd_cor_n = (which != 1); rd_raw_n = (which != 2);
        #1;
        v = rbus;
        rd_in_n = 1'b1; rd_cor_n = 1'b1; rd_raw_n = 1'b1;
        #1;
    endtask

    task automatic walk(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] v;
        fix_n = 1'b1; hold_in_en = 1'b1; in_data = b;
        out_sel_n = 1'b1; wr_sel = 1'b0; mux_sel = 1'b0;
        stor_din = ~a;
        repeat (5) step();
        stor_din = a;
        step();
        step();
        bus_read(0, v); chk("R4 input hold", v, b);
        bus_read(1, v); chk("R2 corrected hold", v, ~a);
        bus_read(2, v); chk("R2 raw hold", v, a);
        rd_raw_n = 1'b0; #1;
        chk("R5 driven flag", {15'd0, rbus_driven}, 16'd1);
        step();
        chk("R7 out from bus", out_data, a);
        chk("R9 write from bus inverted", stor_out_n, ~a);
        rd_raw_n = 1'b1; out_sel_n = 1'b0; wr_sel = 1'b1; mux_sel = 1'b1;
        step();
        chk("R7 out from corrected", out_data, ~a);
        chk("R8 write from corrected", stor_out_n, a);
        mux_sel = 1'b0;
        step();
        chk("R8 write from input", stor_out_n, ~b);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        logic [W-1:0] seq [8];
        stor_din = 16'hFFFF; in_data = 16'hFFFF;
        step(); step();
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 out_data", out_data, '0);
        chk("R1 stor_out_n", stor_out_n, '1);
        bus_read(0, v); chk("R1 input hold", v, '0);
        bus_read(1, v); chk("R1 corrected hold", v, '0);
        bus_read(2, v); chk("R1 raw hold", v, '0);

        // R6 released bus with external value
        bus_ext = 16'hC3A5; #1;
        chk("R6 bus external", rbus, 16'hC3A5);
        chk("R6 driven flag low", {15'd0, rbus_driven}, 16'd0);
        out_sel_n = 1'b1; wr_sel = 1'b0;
        step();
        chk("R7 out from external bus", out_data, 16'hC3A5);
        chk("R9 write from external bus", stor_out_n, 16'h3C5A);

        // R2 latency with a numbered sequence
        fix_n = 1'b1;
        for (int k = 0; k < 8; k++) seq[k] = 16'h1111 * 16'(k + 1);
        for (int k = 0; k < 8; k++) begin
            stor_din = seq[k];
            step();
            if (k >= 1) begin bus_read(2, v); chk("R2 raw one edge", v, seq[k-1]); end
            if (k >= 4) begin bus_read(1, v); chk("R2 corrected four edges", v, seq[k-4]); end
        end

        // walking one and walking zero
        for (int i = 0; i < W; i++) begin
            walk(16'(1) << i, 16'h8000 >> i);
            walk(~(16'(1) << i), ~(16'h8000 >> i));
        end

        // R3 mask applied and ignored
        stor_din = 16'h5A3C; flip_mask = 16'h0FF0; fix_n = 1'b1;
        out_sel_n = 1'b0; wr_sel = 1'b0;
        repeat (5) step();
        fix_n = 1'b0;
        step();
        chk("R3 mask applied to output", out_data, 16'h5A3C ^ 16'h0FF0);
        bus_read(1, v); chk("R3 mask applied to hold", v, 16'h5A3C ^ 16'h0FF0);
        fix_n = 1'b1;
        step();
        chk("R3 mask ignored when strobe high", out_data, 16'h5A3C);
        bus_read(1, v); chk("R3 hold unmasked", v, 16'h5A3C);

        // R4 load enable off keeps value
        hold_in_en = 1'b1; in_data = 16'h1234;
        step();
        hold_in_en = 1'b0; in_data = 16'hFEDC;
        step(); step();
        bus_read(0, v); chk("R4 hold kept with enable off", v, 16'h1234);
        hold_in_en = 1'b1;
        step();
        bus_read(0, v); chk("R4 hold loads with enable on", v, 16'hFEDC);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule